// File: doc/BRIEF.md
# Timer Pin I/O and Capture Flags

This block holds the logic on the single I/O pin of a timer channel. A three-bit function field picks the pin's role: disabled, edge capture, or plain GPIO. In GPIO mode a two-bit drive field either leaves the pin as an input or drives it low or high through an output-enable. In capture mode the synchronized pin is watched for edges. A chosen edge type raises sticky status flags, and together these feed one interrupt line that has its own enable.

Software reads the synchronized pin level in every mode. It clears status flags by writing ones to them. The pin passes through a synchronizer before any logic uses it. A flag that is set by a new event in the same cycle as a clear write stays set, so no event is lost. The counter logic of the timer is outside this block.

Top module: `tmr_pin_io`

## Requirements
- R1: After reset the status flags are 0000, irq is 0, pin_oe is 0 and pin_level is 0.
- R2: pin_level equals pin_i delayed by two clock edges (two-flop synchronizer), in every pin function.
- R3: With pin_func = 3'd4 (GPIO), gpio_ctl = 2'b10 gives pin_oe=1 and pin_o=0, and 2'b11 gives pin_oe=1 and pin_o=1. gpio_ctl 2'b00 and 2'b01 give pin_oe=0.
- R4: For any pin_func other than 3'd4, including 3'd1 (capture), 3'd0 (off) and unused codes, pin_oe is 0 whatever gpio_ctl holds.
- R5: Flag bit 0 (capture event) sets only with pin_func = 3'd1 when the synchronized pin shows an edge that edge_sel admits. edge_sel 2'b01 admits rising edges, 2'b10 admits falling edges, 2'b11 admits both, and 2'b00 admits none.
- R6: In capture mode, flag bit 1 sets on every synchronized rising edge and flag bit 2 sets on every synchronized falling edge, whatever edge_sel holds.
- R7: Flag bit 3 (overrun) sets when an admitted capture edge arrives while flag bit 0 is already set.
- R8: With pin_func other than 3'd1, no flag bit ever sets, whatever the pin does.
- R9: A write (stat_clr_we=1) clears each flag bit whose stat_clr_data bit is 1 and leaves the other bits unchanged. With stat_clr_we=0 the flags hold.
- R10: If a flag's set event and its clear write fall in the same cycle, the flag ends set.
- R11: irq is 1 exactly when irq_en is 1 and at least one flag is set. Dropping irq_en does not alter the flags.
- R12: A flag reflects an edge on the clock edge after the one at which pin_level changes, that is, three edges after pin_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_func | input | 3 | Pin function: 0 off, 1 capture, 4 GPIO, others off |
| gpio_ctl | input | 2 | GPIO drive: 00/01 input, 10 drive low, 11 drive high |
| edge_sel | input | 2 | Capture edge: 01 rising, 10 falling, 11 both, 00 none |
| irq_en | input | 1 | Interrupt enable |
| stat_clr_we | input | 1 | Status clear write strobe |
| stat_clr_data | input | 4 | Write-one-to-clear mask for the flags |
| pin_i | input | 1 | Pin level from the pad |
| pin_o | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output-enable |
| pin_level | output | 1 | Synchronized pin level |
| stat_flags | output | 4 | Flags: bit0 capture, bit1 rise seen, bit2 fall seen, bit3 overrun |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle in which a new capture edge sets the same flag. The pin's path to the flags passes through three registers. The bench therefore changes pin_i and raises the clear strobe two falling clock edges later, so that both events meet at the same rising edge. The overrun flag needs a second admitted edge while the first capture is still pending. The stimulus reaches it with a rise, a fall and a rise under rising-only selection, with no clear in between.

// File: rtl/tpio_pkg.sv
package tpio_pkg;

    localparam int FUNC_W = 3;
    localparam int CTL_W  = 2;
    localparam int EDGE_W = 2;
    localparam int FLAG_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        PF_OFF     = 3'd0,
        PF_CAPTURE = 3'd1,
        PF_GPIO    = 3'd4
    } pin_func_e;

    // Synchronized pin view
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_evt_t;

    // Flag layout, MSB first: overrun, fall seen, rise seen, capture
    typedef struct packed {
        logic ovr;
        logic fall_seen;
        logic rise_seen;
        logic cap;
    } flag_t;

    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    function automatic logic edge_admitted(logic [EDGE_W-1:0] sel, pin_evt_t e);
        return (sel[0] & e.rise) | (sel[1] & e.fall);
    endfunction

    function automatic drive_t drive_decode(logic [FUNC_W-1:0] func, logic [CTL_W-1:0] ctl);
        drive_t d;
        d.oe  = (func == PF_GPIO) && ctl[1];
        d.val = d.oe & ctl[0];
        return d;
    endfunction

endpackage

// File: rtl/tpio_sync.sv
module tpio_sync
    import tpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_i,
    output pin_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    always_comb begin
        evt.level = chain[LAST];
        evt.rise  = chain[LAST] & ~prev;
        evt.fall  = ~chain[LAST] & prev;
    end

endmodule

// File: rtl/tpio_drive.sv
module tpio_drive
    import tpio_pkg::*;
(
    input  logic [FUNC_W-1:0] pin_func,
    input  logic [CTL_W-1:0]  gpio_ctl,
    output logic              pin_o,
    output logic              pin_oe
);
    drive_t drv;

    always_comb begin
        drv    = drive_decode(pin_func, gpio_ctl);
        pin_o  = drv.val;
        pin_oe = drv.oe;
    end

endmodule

// File: rtl/tpio_flags.sv
module tpio_flags
    import tpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_mode,
    input  logic [EDGE_W-1:0] edge_sel,
    input  pin_evt_t          evt,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_data,
    input  logic              irq_en,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    flag_t             cur;
    flag_t             set_now;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] nxt;
    logic              cap_evt;

    always_comb begin
        cap_evt           = cap_mode && edge_admitted(edge_sel, evt);
        set_now.cap       = cap_evt;
        set_now.rise_seen = cap_mode && evt.rise;
        set_now.fall_seen = cap_mode && evt.fall;
        set_now.ovr       = cap_evt && cur.cap;
        set_vec           = set_now;
        clr_vec           = clr_we ? clr_data : '0;
    end

    genvar i;
    generate
        for (i = 0; i < FLAG_W; i++) begin : g_bit
            // set takes priority over a same-cycle clear
            assign nxt[i] = set_vec[i] | (flags[i] & ~clr_vec[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    assign cur = flag_t'(flags);
    assign irq = irq_en && (flags != '0);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((flags & $past(clr_data & ~set_vec)) == '0));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((flags & $past(flags)) == $past(flags)));

    p_overrun_r7: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && cur.cap) |=> flags[3]);

endmodule

// File: rtl/tmr_pin_io.sv
module tmr_pin_io
    import tpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   pin_func,
    input  logic [1:0]   gpio_ctl,
    input  logic [1:0]   edge_sel,
    input  logic         irq_en,
    input  logic         stat_clr_we,
    input  logic [3:0]   stat_clr_data,
    input  logic         pin_i,
    output logic         pin_o,
    output logic         pin_oe,
    output logic         pin_level,
    output logic [3:0]   stat_flags,
    output logic         irq
);
    pin_evt_t evt;
    logic     cap_mode;

    assign cap_mode  = (pin_func == PF_CAPTURE);
    assign pin_level = evt.level;

    tpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_i),
        .evt   (evt)
    );

    tpio_drive u_drive (
        .pin_func (pin_func),
        .gpio_ctl (gpio_ctl),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe)
    );

    tpio_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .cap_mode (cap_mode),
        .edge_sel (edge_sel),
        .evt      (evt),
        .clr_we   (stat_clr_we),
        .clr_data (stat_clr_data),
        .irq_en   (irq_en),
        .flags    (stat_flags),
        .irq      (irq)
    );

    p_no_flag_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && !stat_clr_we) |=> $stable(stat_flags));

    p_cap_follow_r12: assert property (@(posedge clk) disable iff (rst)
        ($rose(pin_level) && cap_mode && edge_sel[0]) |=> stat_flags[0]);

    p_oe_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && !pin_o) |-> (gpio_ctl == 2'b10));

endmodule

// File: tb/sim_tmr_pin_io.sv
module sim_tmr_pin_io;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pin_func = 3'd0;
    logic [1:0] gpio_ctl = 2'b00;
    logic [1:0] edge_sel = 2'b00;
    logic       irq_en = 1'b0;
    logic       stat_clr_we = 1'b0;
    logic [3:0] stat_clr_data = 4'h0;
    logic       pin_i = 1'b0;
    logic       pin_o, pin_oe, pin_level, irq;
    logic [3:0] stat_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pin_io u0 (
        .clk(clk), .rst(rst), .pin_func(pin_func), .gpio_ctl(gpio_ctl),
        .edge_sel(edge_sel), .irq_en(irq_en), .stat_clr_we(stat_clr_we),
        .stat_clr_data(stat_clr_data), .pin_i(pin_i), .pin_o(pin_o),
        .pin_oe(pin_oe), .pin_level(pin_level), .stat_flags(stat_flags), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pin change settles in the flags three edges later
    task automatic move_pin(input logic v);
        pin_i = v;
        step(3);
    endtask

    task automatic clear(input logic [3:0] m);
        stat_clr_we = 1'b1; stat_clr_data = m;
        step(1);
        stat_clr_we = 1'b0; stat_clr_data = 4'h0;
    endtask

    task automatic t_reset;
        check("R1 flags", {4'h0, stat_flags}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 oe", {7'd0, pin_oe}, 8'h00);
        check("R1 level", {7'd0, pin_level}, 8'h00);
    endtask

    task automatic t_gpio;
        pin_func = 3'd4;
        gpio_ctl = 2'b10; step(1);
        check("R3 low", {6'd0, pin_oe, pin_o}, 8'h02);
        gpio_ctl = 2'b11; step(1);
        check("R3 high", {6'd0, pin_oe, pin_o}, 8'h03);
        gpio_ctl = 2'b00; step(1);
        check("R3 input00", {7'd0, pin_oe}, 8'h00);
        gpio_ctl = 2'b01; step(1);
        check("R3 input01", {7'd0, pin_oe}, 8'h00);
    endtask

    task automatic t_oe_other;
        gpio_ctl = 2'b11;
        pin_func = 3'd1; step(1);
        check("R4 capture", {7'd0, pin_oe}, 8'h00);
        pin_func = 3'd0; step(1);
        check("R4 off", {7'd0, pin_oe}, 8'h00);
        pin_func = 3'd6; step(1);
        check("R4 unused", {7'd0, pin_oe}, 8'h00);
        pin_func = 3'd5; step(1);
        check("R4 unused5", {7'd0, pin_oe}, 8'h00);
        gpio_ctl = 2'b00;
    endtask

    task automatic t_level_no_flags;
        pin_func = 3'd0;
        pin_i = 1'b1;
        step(1);
        check("R2 one edge", {7'd0, pin_level}, 8'h00);
        step(1);
        check("R2 two edges", {7'd0, pin_level}, 8'h01);
        step(1);
        move_pin(1'b0);
        check("R2 low", {7'd0, pin_level}, 8'h00);
        check("R8 off", {4'h0, stat_flags}, 8'h00);
        pin_func = 3'd4; edge_sel = 2'b11;
        move_pin(1'b1);
        move_pin(1'b0);
        check("R8 gpio", {4'h0, stat_flags}, 8'h00);
    endtask

    task automatic t_edges;
        pin_func = 3'd1;
        edge_sel = 2'b01;
        pin_i = 1'b1;
        step(2);
        check("R12 not yet", {4'h0, stat_flags}, 8'h00);
        step(1);
        check("R5 R6 rise/rise", {4'h0, stat_flags}, 8'h03);
        clear(4'hF);
        move_pin(1'b0);
        check("R5 R6 rise/fall", {4'h0, stat_flags}, 8'h04);
        clear(4'hF);
        edge_sel = 2'b10;
        move_pin(1'b1);
        check("R5 fall/rise", {4'h0, stat_flags}, 8'h02);
        clear(4'hF);
        move_pin(1'b0);
        check("R5 fall/fall", {4'h0, stat_flags}, 8'h05);
        clear(4'hF);
        edge_sel = 2'b11;
        move_pin(1'b1);
        check("R5 both/rise", {4'h0, stat_flags}, 8'h03);
        clear(4'hF);
        move_pin(1'b0);
        check("R5 both/fall", {4'h0, stat_flags}, 8'h05);
        clear(4'hF);
        edge_sel = 2'b00;
        move_pin(1'b1);
        check("R5 R6 none/rise", {4'h0, stat_flags}, 8'h02);
        move_pin(1'b0);
        clear(4'hF);
        check("R9 clear all", {4'h0, stat_flags}, 8'h00);
    endtask

    task automatic t_overrun;
        edge_sel = 2'b01;
        move_pin(1'b1);
        move_pin(1'b0);
        check("R7 no overrun yet", {4'h0, stat_flags}, 8'h07);
        move_pin(1'b1);
        check("R7 overrun", {4'h0, stat_flags}, 8'h0F);
    endtask

    task automatic t_w1c;
        clear(4'h5);
        check("R9 partial", {4'h0, stat_flags}, 8'h0A);
        clear(4'h0);
        check("R9 zero mask", {4'h0, stat_flags}, 8'h0A);
        stat_clr_we = 1'b0; stat_clr_data = 4'hF; step(1);
        stat_clr_data = 4'h0;
        check("R9 no strobe", {4'h0, stat_flags}, 8'h0A);
        clear(4'hF);
        check("R9 all", {4'h0, stat_flags}, 8'h00);
    endtask

    task automatic t_set_wins;
        // pin is high here; bring low, then capture a rise with a colliding clear
        move_pin(1'b0);
        move_pin(1'b1);
        clear(4'hF);
        check("R10 setup", {4'h0, stat_flags}, 8'h00);
        move_pin(1'b0);
        move_pin(1'b1);
        check("R10 pre", {4'h0, stat_flags}, 8'h07);
        move_pin(1'b0);
        pin_i = 1'b1;
        step(2);
        stat_clr_we = 1'b1; stat_clr_data = 4'h1;
        step(1);
        stat_clr_we = 1'b0; stat_clr_data = 4'h0;
        check("R10 set wins", {4'h0, stat_flags}, 8'h0F);
    endtask

    task automatic t_irq;
        irq_en = 1'b0; step(1);
        check("R11 masked", {7'd0, irq}, 8'h00);
        check("R11 flags kept", {4'h0, stat_flags}, 8'h0F);
        irq_en = 1'b1; step(1);
        check("R11 raised", {7'd0, irq}, 8'h01);
        clear(4'hE);
        check("R11 one flag", {7'd0, irq}, 8'h01);
        clear(4'h1);
        check("R11 cleared", {7'd0, irq}, 8'h00);
        irq_en = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_gpio();
        t_oe_other();
        t_level_no_flags();
        t_edges();
        t_overrun();
        t_w1c();
        t_set_wins();
        t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule